// File: doc/BRIEF.md
# Shadow RAM Store/Recall Controller

This block guards the transfers between a small volatile working RAM and a nonvolatile shadow copy of the same size. Both arrays are modelled as registers. The nonvolatile side has a programmable per-word copy time, which stands in for the long program time of real cells. A serial front end hands the block decoded commands and host write requests. Two active-low board pins can also ask for a store (RAM to shadow) or a recall (shadow to RAM).

Two latches protect the shadow array: a write-enable flag and a flag recording that a deliberate recall has been done. A store starts only when both flags are set. When a store finishes, the write-enable flag is cleared again. After reset the block fills the RAM from the shadow array on its own. That automatic recall does not count as a deliberate recall. While any copy runs, a busy output tells the serial front end to ignore the host and to float its data line. Host reads are served at any time.

Top module: `nvg_guard`

## Requirements
- R1: Reset clears both latches and starts an automatic recall. `busy` is high during reset and during that recall. Afterwards RAM word i equals `NV_SEED ^ (i*16'h1111)` (default seed 16'hA5C3), and host writes are refused.
- R2: While `busy` is high, a command pulse on `cmd_valid` has no effect.
- R3: The automatic recall does not set the recall latch. A store command issued after only an enable command is refused, and `busy` stays low.
- R4: A recall command (`cmd_op` = 3'b101) or a falling edge of the synchronised `recall_n` copies the whole shadow array into RAM and sets the recall latch.
- R5: Command 3'b100 sets the write-enable latch. Command 3'b000 clears it.
- R6: A host write (`wr_req`) changes RAM only while the write-enable latch is set and `busy` is low.
- R7: A store command (3'b001) or a falling edge of the synchronised `store_n` copies RAM into the shadow array. It does so only when both latches are set; otherwise the request is dropped.
- R8: When a store completes, the write-enable latch is cleared, so a later host write is refused.
- R9: A pin edge is accepted only while `busy` is low, `instr_active` is low and `cmd_valid` is low in that cycle. Otherwise the edge is dropped.
- R10: If both pins fall in the same cycle, only the recall runs.
- R11: `busy` stays high for exactly WORDS*max(1,RECALL_CYCLES/WORDS) cycles for a recall and WORDS*max(1,STORE_CYCLES/WORDS) cycles for a store. With the defaults this is 32 and 256 cycles.
- R12: The command codes 3'b010, 3'b011, 3'b110 and 3'b111 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cmd_valid | input | 1 | One-cycle pulse carrying a decoded command |
| cmd_op | input | 3 | Command code |
| instr_active | input | 1 | Serial front end is in the middle of an instruction |
| wr_req | input | 1 | Host RAM write strobe |
| wr_addr | input | log2(WORDS) | Host write word address |
| wr_data | input | WIDTH | Host write data |
| rd_addr | input | log2(WORDS) | Host read word address |
| rd_data | output | WIDTH | RAM word at `rd_addr` |
| store_n | input | 1 | Asynchronous active-low store request pin |
| recall_n | input | 1 | Asynchronous active-low recall request pin |
| busy | output | 1 | A copy sequence is running |

## Verification
Two kinds of request can arrive in the same cycle: a store pin edge and a recall pin edge. The bench drives both pins low on the same clock edge after RAM holds a word that differs from the shadow array. It then judges the outcome from RAM contents. If the word reverts to its shadow value, the recall ran alone. If the RAM value survives, the store was wrongly chosen. Pin edges that arrive while the front end reports an instruction in flight are treated the same way: the bench confirms that `busy` never rises and that RAM is untouched.

// File: rtl/nvg_pkg.sv
package nvg_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_RECALL = 2'd1,
        SEQ_STORE  = 2'd2
    } seq_state_e;

    localparam logic [2:0] OP_WR_OFF = 3'b000;
    localparam logic [2:0] OP_STORE  = 3'b001;
    localparam logic [2:0] OP_WR_ON  = 3'b100;
    localparam logic [2:0] OP_RECALL = 3'b101;

endpackage

// File: rtl/nvg_pin_sync.sv
module nvg_pin_sync #(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_n,
    output logic [PINS-1:0] fall
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } pin_s;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        pin_s pin_d, pin_q;

        always_comb begin
            pin_d      = pin_q;
            pin_d.meta = pin_n[g];
            pin_d.sync = pin_q.meta;
            pin_d.prev = pin_q.sync;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
            end else begin
                pin_q <= pin_d;
            end
        end

        assign fall[g] = pin_q.prev & ~pin_q.sync;
    end

endmodule

// File: rtl/nvg_ctrl.sv
module nvg_ctrl
    import nvg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       instr_active,
    input  logic       store_fall,
    input  logic       recall_fall,
    input  logic       wr_req,
    input  logic       busy,
    input  logic       store_done,
    output logic       start_store,
    output logic       start_recall,
    output logic       host_wr,
    output logic       we_q,
    output logic       pr_q
);

    typedef struct packed {
        logic we;
        logic pr;
    } latch_s;

    latch_s lat_d, lat_q;
    logic   cmd_ok;
    logic   pin_ok;
    logic   may_store;

    always_comb begin
        lat_d        = lat_q;
        start_store  = 1'b0;
        start_recall = 1'b0;
        cmd_ok       = cmd_valid && !busy;
        pin_ok       = !busy && !instr_active && !cmd_valid;
        may_store    = lat_q.we && lat_q.pr;

        if (cmd_ok) begin
            unique case (cmd_op)
                OP_WR_ON:  lat_d.we = 1'b1;
                OP_WR_OFF: lat_d.we = 1'b0;
                OP_RECALL: begin
                    start_recall = 1'b1;
                    lat_d.pr     = 1'b1;
                end
                OP_STORE:  start_store = may_store;
                default:   ;
            endcase
        end else if (pin_ok) begin
            if (recall_fall) begin
                start_recall = 1'b1;
                lat_d.pr     = 1'b1;
            end else if (store_fall) begin
                start_store = may_store;
            end
        end

        if (store_done) begin
            lat_d.we = 1'b0;
        end

        host_wr = wr_req && lat_q.we && !busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '{we: 1'b0, pr: 1'b0};
        end else begin
            lat_q <= lat_d;
        end
    end

    assign we_q = lat_q.we;
    assign pr_q = lat_q.pr;

endmodule

// File: rtl/nvg_copy_seq.sv
module nvg_copy_seq
    import nvg_pkg::*;
#(
    parameter int WORDS         = 16,
    parameter int STORE_CYCLES  = 256,
    parameter int RECALL_CYCLES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_store,
    input  logic                     start_recall,
    output logic                     busy,
    output logic                     st_store,
    output logic                     st_recall,
    output logic                     step,
    output logic                     done,
    output logic [$clog2(WORDS)-1:0] idx
);

    localparam int AW    = $clog2(WORDS);
    localparam int W_ST  = (STORE_CYCLES / WORDS) < 1 ? 1 : STORE_CYCLES / WORDS;
    localparam int W_RC  = (RECALL_CYCLES / WORDS) < 1 ? 1 : RECALL_CYCLES / WORDS;
    localparam int W_MAX = W_ST > W_RC ? W_ST : W_RC;
    localparam int TW    = $clog2(W_MAX) + 1;

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] idx;
        logic [TW-1:0] tmr;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        busy  = seq_q.state != SEQ_IDLE;
        step  = busy && (seq_q.tmr == '0);
        done  = step && (seq_q.idx == AW'(WORDS - 1));

        if (!busy) begin
            seq_d.idx = '0;
            if (start_recall) begin
                seq_d.state = SEQ_RECALL;
                seq_d.tmr   = TW'(W_RC - 1);
            end else if (start_store) begin
                seq_d.state = SEQ_STORE;
                seq_d.tmr   = TW'(W_ST - 1);
            end
        end else if (step) begin
            if (done) begin
                seq_d.state = SEQ_IDLE;
                seq_d.idx   = '0;
            end else begin
                seq_d.idx = seq_q.idx + 1'b1;
                seq_d.tmr = (seq_q.state == SEQ_STORE) ? TW'(W_ST - 1) : TW'(W_RC - 1);
            end
        end else begin
            seq_d.tmr = seq_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_RECALL, idx: '0, tmr: TW'(W_RC - 1)};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_store  = seq_q.state == SEQ_STORE;
    assign st_recall = seq_q.state == SEQ_RECALL;
    assign idx       = seq_q.idx;

endmodule

// File: rtl/nvg_arrays.sv
module nvg_arrays #(
    parameter int          WORDS   = 16,
    parameter int          WIDTH   = 16,
    parameter logic [15:0] NV_SEED = 16'hA5C3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_wr,
    input  logic [$clog2(WORDS)-1:0]        wr_addr,
    input  logic [WIDTH-1:0]                wr_data,
    input  logic [$clog2(WORDS)-1:0]        rd_addr,
    output logic [WIDTH-1:0]                rd_data,
    input  logic                            step,
    input  logic                            to_shadow,
    input  logic [$clog2(WORDS)-1:0]        idx,
    output logic [WORDS-1:0][WIDTH-1:0]     ram_q,
    output logic [WORDS-1:0][WIDTH-1:0]     nv_q
);

    typedef logic [WORDS-1:0][WIDTH-1:0] bank_t;

    typedef struct packed {
        bank_t ram;
        bank_t nv;
    } arr_s;

    arr_s arr_d, arr_q;

    function automatic bank_t shadow_init();
        bank_t b;
        for (int i = 0; i < WORDS; i++) begin
            b[i] = WIDTH'(NV_SEED) ^ WIDTH'(i * 32'h1111);
        end
        return b;
    endfunction

    always_comb begin
        arr_d = arr_q;
        if (host_wr) begin
            arr_d.ram[wr_addr] = wr_data;
        end
        if (step) begin
            if (to_shadow) begin
                arr_d.nv[idx] = arr_q.ram[idx];
            end else begin
                arr_d.ram[idx] = arr_q.nv[idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q.ram <= '0;
            arr_q.nv  <= shadow_init();
        end else begin
            arr_q <= arr_d;
        end
    end

    assign rd_data = arr_q.ram[rd_addr];
    assign ram_q   = arr_q.ram;
    assign nv_q    = arr_q.nv;

endmodule

// File: rtl/nvg_guard.sv
module nvg_guard #(
    parameter int          WORDS         = 16,
    parameter int          WIDTH         = 16,
    parameter int          STORE_CYCLES  = 256,
    parameter int          RECALL_CYCLES = 32,
    parameter logic [15:0] NV_SEED       = 16'hA5C3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic                     instr_active,
    input  logic                     wr_req,
    input  logic [$clog2(WORDS)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data,
    input  logic                     store_n,
    input  logic                     recall_n,
    output logic                     busy
);

    localparam int AW = $clog2(WORDS);

    logic [1:0]                 pin_fall;
    logic                       start_store, start_recall;
    logic                       host_wr, we_q, pr_q;
    logic                       st_store, st_recall, step, seq_done;
    logic [AW-1:0]              seq_idx;
    logic [WORDS-1:0][WIDTH-1:0] ram_q, nv_q;

    nvg_pin_sync #(.PINS(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({recall_n, store_n}),
        .fall  (pin_fall)
    );

    nvg_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .instr_active (instr_active),
        .store_fall   (pin_fall[0]),
        .recall_fall  (pin_fall[1]),
        .wr_req       (wr_req),
        .busy         (busy),
        .store_done   (seq_done && st_store),
        .start_store  (start_store),
        .start_recall (start_recall),
        .host_wr      (host_wr),
        .we_q         (we_q),
        .pr_q         (pr_q)
    );

    nvg_copy_seq #(
        .WORDS         (WORDS),
        .STORE_CYCLES  (STORE_CYCLES),
        .RECALL_CYCLES (RECALL_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_store  (start_store),
        .start_recall (start_recall),
        .busy         (busy),
        .st_store     (st_store),
        .st_recall    (st_recall),
        .step         (step),
        .done         (seq_done),
        .idx          (seq_idx)
    );

    nvg_arrays #(
        .WORDS   (WORDS),
        .WIDTH   (WIDTH),
        .NV_SEED (NV_SEED)
    ) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .step      (step),
        .to_shadow (st_store),
        .idx       (seq_idx),
        .ram_q     (ram_q),
        .nv_q      (nv_q)
    );

endmodule

// File: rtl/nvg_guard_chk.sv
module nvg_guard_chk #(
    parameter int WORDS = 16,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   we_q,
    input logic                   pr_q,
    input logic                   st_store,
    input logic                   st_recall,
    input logic                   seq_done,
    input logic                   start_store,
    input logic                   start_recall,
    input logic [WORDS*WIDTH-1:0] ram_flat,
    input logic [WORDS*WIDTH-1:0] nv_flat
);

    // R2: the latches hold while a copy runs, except the completion cycle
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_done) |=> ($stable(we_q) && $stable(pr_q)));

    // R4: the recall latch rises only together with a recall sequence
    p_recall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_q) |-> st_recall);

    // R6: with writes disabled and idle, RAM cannot change
    p_ram_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_q && !busy) |=> $stable(ram_flat));

    // R7: a store sequence only begins when both latches were set
    p_store_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_store) |-> $past(we_q && pr_q));

    // R7: the shadow array is untouched while no copy runs
    p_shadow_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(nv_flat));

    // R8: write enable drops after the last stored word
    p_we_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_store && seq_done) |=> !we_q);

    // R10: never both kinds of start in one cycle
    p_one_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_store, start_recall}));

endmodule

bind nvg_guard nvg_guard_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .we_q         (we_q),
    .pr_q         (pr_q),
    .st_store     (st_store),
    .st_recall    (st_recall),
    .seq_done     (seq_done),
    .start_store  (start_store),
    .start_recall (start_recall),
    .ram_flat     (ram_q),
    .nv_flat      (nv_q)
);

// File: tb/test_nvg_guard.sv
module test_nvg_guard;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 16;
    localparam int WIDTH      = 16;
    localparam int RC_LEN     = 32;
    localparam int ST_LEN     = 256;

    localparam logic [3:0] K_CMD  = 4'd1;
    localparam logic [3:0] K_WR   = 4'd2;
    localparam logic [3:0] K_RD   = 4'd3;
    localparam logic [3:0] K_BUSY = 4'd4;

    // {kind, op, addr, requirement number, data}
    localparam int NVEC = 17;
    localparam logic [31:0] VEC [NVEC] = '{
        {K_CMD,  4'h4, 4'h0, 4'd5,  16'h0000}, // R5 enable
        {K_WR,   4'h0, 4'h3, 4'd6,  16'h1234},
        {K_RD,   4'h0, 4'h3, 4'd6,  16'h1234}, // R6 accepted
        {K_CMD,  4'h1, 4'h0, 4'd3,  16'h0000}, // R3 store with no user recall
        {K_BUSY, 4'h0, 4'h0, 4'd3,  16'h0000}, // R3 refused
        {K_CMD,  4'h0, 4'h0, 4'd5,  16'h0000}, // R5 disable
        {K_WR,   4'h0, 4'h3, 4'd5,  16'h5555},
        {K_RD,   4'h0, 4'h3, 4'd5,  16'h1234}, // R5 write refused
        {K_CMD,  4'h4, 4'h0, 4'd12, 16'h0000},
        {K_CMD,  4'h2, 4'h0, 4'd12, 16'h0000}, // R12 reserved codes
        {K_CMD,  4'h3, 4'h0, 4'd12, 16'h0000},
        {K_CMD,  4'h6, 4'h0, 4'd12, 16'h0000},
        {K_CMD,  4'h7, 4'h0, 4'd12, 16'h0000},
        {K_BUSY, 4'h0, 4'h0, 4'd12, 16'h0000},
        {K_WR,   4'h0, 4'h4, 4'd12, 16'h0F0F},
        {K_RD,   4'h0, 4'h4, 4'd12, 16'h0F0F}, // R12 enable survived
        {K_CMD,  4'h0, 4'h0, 4'd5,  16'h0000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_op = 3'b0;
    logic             instr_active = 1'b0;
    logic             wr_req = 1'b0;
    logic [3:0]       wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [3:0]       rd_addr = '0;
    logic [WIDTH-1:0] rd_data;
    logic             store_n = 1'b1;
    logic             recall_n = 1'b1;
    logic             busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvg_guard i_nvg_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .instr_active (instr_active),
        .wr_req       (wr_req),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .store_n      (store_n),
        .recall_n     (recall_n),
        .busy         (busy)
    );

    function automatic logic [WIDTH-1:0] shadow_word(int i);
        return 16'hA5C3 ^ WIDTH'(i * 32'h1111);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic host_write(input logic [3:0] a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_req  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic read_chk(input logic [3:0] a, input logic [WIDTH-1:0] exp, input string req);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pins(input bit do_store, input bit do_recall);
        @(negedge clk);
        store_n  = !do_store;
        recall_n = !do_recall;
        repeat (4) @(negedge clk);
        store_n  = 1'b1;
        recall_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1, "R1 busy in reset", busy, 1);
        rst_n = 1'b1;
        // R1/R11 power-up recall length; R2 a command mid-way is ignored
        n = 0;
        while (busy && n < 1000) begin
            n++;
            cmd_valid = (n == 5);
            cmd_op    = 3'b100;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(n == RC_LEN, "R11 power-up recall length", n, RC_LEN);
        for (int i = 0; i < WORDS; i++) begin
            read_chk(4'(i), shadow_word(i), "R1 power-up contents");
        end
        host_write(4'h0, 16'hFFFF);
        read_chk(4'h0, shadow_word(0), "R2 enable during recall ignored");

        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] e;
            string tag;
            e = VEC[v];
            tag = $sformatf("R%0d vector %0d", e[19:16], v);
            case (e[31:28])
                K_CMD:  cmd(e[26:24]);
                K_WR:   host_write(e[23:20], e[15:0]);
                K_RD:   read_chk(e[23:20], e[15:0], tag);
                K_BUSY: chk(busy === e[0], tag, busy, e[0]);
                default: ;
            endcase
        end

        // R4 software recall restores word 3; R11 recall length
        cmd(3'b101);
        busy_len(n);
        chk(n == RC_LEN, "R11 recall length", n, RC_LEN);
        read_chk(4'h3, shadow_word(3), "R4 recall restores");

        // R2 a disable during a recall is ignored
        cmd(3'b100);
        cmd(3'b101);
        cmd(3'b000);
        wait_idle();
        host_write(4'hA, 16'hAAAA);
        read_chk(4'hA, 16'hAAAA, "R2 disable while busy ignored");

        // R7 store, R11 store length, R8 enable dropped after store
        host_write(4'h5, 16'hBEEF);
        cmd(3'b001);
        busy_len(n);
        chk(n == ST_LEN, "R11 store length", n, ST_LEN);
        host_write(4'h6, 16'h1111);
        read_chk(4'h6, shadow_word(6), "R8 write after store refused");
        host_write(4'h5, 16'h0000);
        cmd(3'b101);
        wait_idle();
        read_chk(4'h5, 16'hBEEF, "R7 stored word recalled");

        // R4 recall pin
        cmd(3'b100);
        host_write(4'h5, 16'h0000);
        pins(1'b0, 1'b1);
        chk(busy === 1'b1, "R4 recall pin starts copy", busy, 1);
        wait_idle();
        read_chk(4'h5, 16'hBEEF, "R4 recall pin contents");

        // R7 store pin (enable still set, recall latch set)
        host_write(4'h7, 16'h7777);
        pins(1'b1, 1'b0);
        wait_idle();
        host_write(4'h7, 16'h0000);
        cmd(3'b101);
        wait_idle();
        read_chk(4'h7, 16'h7777, "R7 store pin contents");

        // R10 both pins at once: recall only
        cmd(3'b100);
        host_write(4'h8, 16'h8888);
        pins(1'b1, 1'b1);
        wait_idle();
        read_chk(4'h8, shadow_word(8), "R10 recall wins");
        host_write(4'h8, 16'h8181);
        read_chk(4'h8, 16'h8181, "R10 no store ran, enable kept");

        // R9 pin edge dropped while an instruction is in flight
        host_write(4'h9, 16'h9999);
        instr_active = 1'b1;
        pins(1'b0, 1'b1);
        chk(busy === 1'b0, "R9 pin ignored during instruction", busy, 0);
        instr_active = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R9 no late start", busy, 0);
        read_chk(4'h9, 16'h9999, "R9 RAM untouched");

        // R6 write during a copy is refused
        cmd(3'b101);
        @(negedge clk);
        wr_req  = 1'b1;
        wr_addr = 4'hB;
        wr_data = 16'h0BAD;
        @(negedge clk);
        wr_req = 1'b0;
        wait_idle();
        read_chk(4'hB, shadow_word(11), "R6 write while busy refused");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule